// File: doc/BRIEF.md
# Sequential Radix-4 Booth Signed Multiplier

This block multiplies two two's-complement operands of an even parameterised width N. It produces a signed product 2N bits wide. The multiplier operand is examined two bits at a time, and each examination also looks at the bit just below the pair. Every pair picks one summand from zero, plus or minus the multiplicand, and plus or minus twice the multiplicand. As a result, only N/2 summands are accumulated. Positive and negative multipliers follow the same path, with no correction step.

The multiplicand is sign-extended to the full product width before any summand is formed. A negative summand is made by inverting the selected value and feeding a carry of one into the accumulator adder. Each cycle retires one pair. The multiplier shifts right by two places with its sign copied in. The multiplicand shifts left by two places.

A single `start` pulse loads both operands, provided the block is idle. While `busy` is high, the block refuses further loads. A second start is neither queued nor buffered, so a caller must wait for `done` before it offers new operands. `done` pulses for one cycle when the product appears. The product then holds until the next accepted start.

Top module: `booth4_seq_mul`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: Each multiplier pair (bit i+1, bit i) is read together with bit i-1 to select a summand. The selections are: 000 gives 0, 001 gives +M, 010 gives +M, 011 gives +2M, 100 gives -2M, 101 gives -M, 110 gives -M, and 111 gives 0. The first pair reads an implied 0 below the multiplier LSB.
- R3: When the multiplier is 1 or 3, the product equals M or 3M. This requires the implied zero below the LSB to be taken into account.
- R4: `product` equals the signed product of `mcand` and `mplier` for any pair of N-bit two's-complement values. For example, -6 times 13 gives -78.
- R5: A start accepted at a clock edge makes `busy` high from that edge onward. `done` then goes high exactly N/2 edges later, for one cycle, and `busy` falls at that same edge.
- R6: A `start` or an operand change while `busy` is high has no effect on the running product or on its timing.
- R7: Outside a run, `product` keeps its last value until the next accepted start.
- R8: A negative multiplicand is sign-extended to 2N bits before summing, so negative-times-negative and negative-times-positive products come out correct, including the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin; honoured only when idle |
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| busy | output | 1 | High while the pairs are being accumulated |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product, held until the next run |

## Verification
The worked case -6 times 13 gives a baseline. Multipliers of 1, 3 and -2 each isolate a few recoder entries, including the implied zero below the LSB. Alternating-bit and long-run multipliers drive every one of the eight selections across later pairs. Negative and extreme operands, such as the most negative value squared and -1 times -1, show whether sign extension and the inverted-plus-carry negation hold at the top of the product. A run that is disturbed by new operands and a repeated start, then left idle, shows whether the product is locked against those inputs and timed exactly.

// File: rtl/booth4_pkg.sv
package booth4_pkg;
  // Summand choice for one multiplier pair
  typedef struct packed {
    logic neg;   // negate the chosen magnitude
    logic one;   // magnitude is M
    logic two;   // magnitude is 2M
  } pick_t;
endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
(
  input  logic [2:0] trip,   // {bit i+1, bit i, bit i-1}
  output pick_t      pick
);
  always_comb begin
    pick = '0;
    unique case (trip)
      3'b000, 3'b111: pick = '0;
      3'b001, 3'b010: pick.one = 1'b1;
      3'b011:         pick.two = 1'b1;
      3'b100:         begin pick.two = 1'b1; pick.neg = 1'b1; end
      3'b101, 3'b110: begin pick.one = 1'b1; pick.neg = 1'b1; end
      default:        pick = '0;
    endcase
  end

  // R2: never both magnitudes, and never a negated zero
  always_comb begin
    a_r2_pick_exclusive: assert (!(pick.one && pick.two));
    a_r2_no_neg_zero:    assert (!pick.neg || pick.one || pick.two);
  end
endmodule

// File: rtl/booth4_summand.sv
module booth4_summand
  import booth4_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] mc_sh,   // sign-extended, shifted multiplicand
  input  pick_t         pick,
  output logic [PW-1:0] addend,
  output logic          cin
);
  logic [PW-1:0] mag;

  always_comb begin
    if (pick.two)      mag = mc_sh << 1;
    else if (pick.one) mag = mc_sh;
    else               mag = '0;
    addend = pick.neg ? ~mag : mag;
    cin    = pick.neg;
  end
endmodule

// File: rtl/booth4_accum.sv
module booth4_accum #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] acc,
  input  logic [PW-1:0] addend,
  input  logic          cin,
  output logic [PW-1:0] sum
);
  always_comb sum = acc + addend + {{(PW-1){1'b0}}, cin};
endmodule

// File: rtl/booth4_seq_mul.sv
module booth4_seq_mul
  import booth4_pkg::*;
#(
  parameter int unsigned N = 8   // operand width, must be even
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int unsigned PW    = 2 * N;
  localparam int unsigned STEPS = N / 2;
  localparam int unsigned CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [PW-1:0] acc_q, mc_q, addend, sum;
  logic [N:0]    q_q;      // multiplier with implied zero below LSB
  logic [CW-1:0] cnt_q;
  logic          cin;
  pick_t         pick;

  booth4_recoder u_rec (.trip(q_q[2:0]), .pick(pick));

  booth4_summand #(.PW(PW)) u_sum (
    .mc_sh(mc_q), .pick(pick), .addend(addend), .cin(cin)
  );

  booth4_accum #(.PW(PW)) u_acc (
    .acc(acc_q), .addend(addend), .cin(cin), .sum(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mc_q    <= '0;
      q_q     <= '0;
      cnt_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc_q <= sum;
        mc_q  <= mc_q << 2;
        q_q   <= {q_q[N], q_q[N], q_q[N:2]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= sum;
        end
      end else if (start) begin
        acc_q <= '0;
        mc_q  <= {{N{mcand[N-1]}}, mcand};
        q_q   <= {mplier, 1'b0};
        cnt_q <= '0;
        busy  <= 1'b1;
      end
    end
  end

  // R5: done is a single-cycle pulse that ends a run
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LAST));
  // R6: a start during a run does not cut it short
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt_q != LAST) |=> busy);
  // R7: product only moves when a run completes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
endmodule

// File: tb/booth4_seq_mul_tb.sv
module booth4_seq_mul_tb;
  localparam int N = 8;
  localparam int STEPS = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  booth4_seq_mul #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Run one multiply, checking timing cycle by cycle and the result
  task automatic run_mul(input string req, input int a, input int b,
                         input bit disturb);
    logic [2*N-1:0] exp;
    exp = 16'(a * b);
    @(negedge clk);
    mcand = N'(a); mplier = N'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R5 busy after start"}, 64'(busy), 64'd1);
    for (int k = 1; k <= STEPS; k++) begin
      if (disturb) begin
        mcand = ~mcand; mplier = mplier + 8'd37; start = 1'b1;
      end
      @(negedge clk);
      chk({req, " R5 done timing"}, 64'(done), 64'(k == STEPS));
      chk({req, " R5 busy timing"}, 64'(busy), 64'(k != STEPS));
    end
    start = 1'b0;
    chk(req, 64'(product), 64'(exp));
  endtask

  task automatic t_reset();
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 product", 64'(product), 64'd0);
  endtask

  task automatic t_worked();
    run_mul("R4 -6*13", -6, 13, 0);
  endtask

  task automatic t_implied_zero();
    run_mul("R3 M*1", 57, 1, 0);
    run_mul("R3 M*3", 57, 3, 0);
    run_mul("R3 -M*3", -57, 3, 0);
  endtask

  task automatic t_table();
    run_mul("R2 -2 (100,111)", 45, -2, 0);
    run_mul("R2 alternating 0x55", 45, 8'h55, 0);
    run_mul("R2 alternating 0xAA", 45, -86, 0);
    run_mul("R2 run 0x3C", -19, 8'h3C, 0);
    run_mul("R2 mixed 0x6B", 99, 8'h6B, 0);
    run_mul("R2 zero mplier", 99, 0, 0);
  endtask

  task automatic t_signs();
    run_mul("R8 -1*-1", -1, -1, 0);
    run_mul("R8 min*min", -128, -128, 0);
    run_mul("R8 min*max", -128, 127, 0);
    run_mul("R8 max*max", 127, 127, 0);
    run_mul("R8 -77*-3", -77, -3, 0);
  endtask

  task automatic t_ignore_and_hold();
    logic [2*N-1:0] held;
    run_mul("R6 disturbed run", -6, 13, 1);
    held = product;
    mcand = 8'd5; mplier = 8'd9;
    repeat (5) @(negedge clk);
    chk("R7 product held", 64'(product), 64'(held));
    chk("R7 stays idle", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_worked();
    t_implied_zero();
    t_table();
    t_signs();
    t_ignore_and_hold();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule